// File: doc/BRIEF.md
# Per-Channel Sample Limit Watchdog

This block watches a stream of converted samples, each tagged with the number of the channel it came from. It compares every sample against a programmable upper limit and a programmable lower limit. Both limits and the sample are two's-complement values of the same width. Each channel keeps two sticky flags. One records that a sample went above the upper limit. The other records that a sample went below the lower limit. A flag stays set until the matching bit of a clear vector is pulsed. A combined interrupt line is raised while any flag is set and the interrupt enable is high.

Two tagged streams arrive at the block. One comes from the main decimation filter. The other comes from a separate coarse, low-latency monitoring filter. A single select input chooses which of the two is watched, and the other stream is ignored entirely. A per-channel enable mask decides which channels may raise flags. The selected sample is registered once at the input (parameter `REG_IN`). With that register in place, a sample presented at clock edge k is reflected in the flags after edge k+1.

Top module: `lim_watch`

## Requirements
- R1: While reset is asserted and directly after it, every bit of `flag_lo` and `flag_hi` is 0 and `irq` is 0.
- R2: A valid sample from the selected stream whose value is strictly greater than `thr_hi` sets bit `ch` of `flag_hi`, where `ch` is the sample's channel tag. The bit is visible after the second rising edge counted from the edge that accepts the sample. A sample equal to `thr_hi` sets nothing.
- R3: A valid sample from the selected stream whose value is strictly less than `thr_lo` sets bit `ch` of `flag_lo`, with the same latency as R2. A sample equal to `thr_lo` sets nothing.
- R4: Samples and both limits are compared as signed two's-complement numbers of `SMP_W` bits. For example, with an upper limit of -5, a sample of 10 trips the upper limit. With a lower limit of -100, a sample of -200 trips the lower limit.
- R5: With `src_sel` = 0 only the main stream (`main_*`) is monitored. With `src_sel` = 1 only the watchdog stream (`wd_*`) is monitored. A sample on the unselected stream never changes any flag.
- R6: A sample whose channel has its bit in `ch_mask` at 0 sets no flag.
- R7: Flags are sticky. A set flag stays 1 through later in-range samples. It returns to 0 only after a cycle in which the bit with the same index in `clr_lo` (for `flag_lo`) or `clr_hi` (for `flag_hi`) is 1, and other bits are not affected.
- R8: If a flag is set and cleared in the same cycle, it ends up set.
- R9: `irq` is 1 exactly when `irq_en` is 1 and at least one bit of `flag_lo` or `flag_hi` is 1.
- R10: A sample sets flags only at the index of its own channel tag, so at most one bit of each flag vector rises per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_sel | input | 1 | 0 watches the main stream, 1 watches the watchdog stream |
| main_vld | input | 1 | Main-filter sample valid |
| main_ch | input | CH_W (3) | Main-filter sample channel tag |
| main_smp | input | SMP_W (24) | Main-filter sample, signed |
| wd_vld | input | 1 | Watchdog-filter sample valid |
| wd_ch | input | CH_W (3) | Watchdog-filter sample channel tag |
| wd_smp | input | SMP_W (24) | Watchdog-filter sample, signed |
| thr_hi | input | SMP_W (24) | Upper limit, signed |
| thr_lo | input | SMP_W (24) | Lower limit, signed |
| ch_mask | input | NUM_CH (8) | Per-channel monitoring enable |
| irq_en | input | 1 | Interrupt enable |
| clr_lo | input | NUM_CH (8) | Clear pulses for the low flags |
| clr_hi | input | NUM_CH (8) | Clear pulses for the high flags |
| flag_lo | output | NUM_CH (8) | Sticky below-lower-limit flags, bit n for channel n |
| flag_hi | output | NUM_CH (8) | Sticky above-upper-limit flags, bit n for channel n |
| irq | output | 1 | Combined limit interrupt |

## Verification
Every piece of internal state is visible at the ports within two edges, so each fault shows up quickly:
- A wrong input register, such as a stale channel tag or the wrong stream chosen, puts a bit in the wrong place of a flag vector two edges after the sample.
- A compare that is wrong in signedness or at the boundary sets or misses a flag at the same point.
- A flag register that loses its sticky hold, or lets a clear beat a set, shows its wrong value one edge after the later sample or the clear pulse.

The sweep uses every channel, both streams, two threshold pairs, and samples on and just across each limit. It checks the full flag vectors after every sample, so any wrong bit is caught on that same sample.

// File: rtl/lim_watch_pkg.sv
package lim_watch_pkg;

   // Monitored stream selection
   typedef enum logic {
      LW_SRC_MAIN  = 1'b0,
      LW_SRC_WATCH = 1'b1
   } lw_src_e;

   // Compare outcome of one sample against the two limits
   typedef struct packed {
      logic above;
      logic below;
   } lw_cmp_t;

   localparam int LW_MAX_CH = 64;

endpackage

// File: rtl/lim_watch_src.sv
module lim_watch_src
   import lim_watch_pkg::*;
#(
   parameter int CH_W   = 3,
   parameter int SMP_W  = 24,
   parameter bit REG_IN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  lw_src_e          sel,
   input  logic             a_vld,
   input  logic [CH_W-1:0]  a_ch,
   input  logic [SMP_W-1:0] a_smp,
   input  logic             b_vld,
   input  logic [CH_W-1:0]  b_ch,
   input  logic [SMP_W-1:0] b_smp,
   output logic             o_vld,
   output logic [CH_W-1:0]  o_ch,
   output logic [SMP_W-1:0] o_smp
);

   logic             m_vld;
   logic [CH_W-1:0]  m_ch;
   logic [SMP_W-1:0] m_smp;

   always_comb begin
      if (sel == LW_SRC_WATCH) begin
         m_vld = b_vld;
         m_ch  = b_ch;
         m_smp = b_smp;
      end else begin
         m_vld = a_vld;
         m_ch  = a_ch;
         m_smp = a_smp;
      end
   end

   generate
      if (REG_IN) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               o_vld <= 1'b0;
               o_ch  <= '0;
               o_smp <= '0;
            end else begin
               o_vld <= m_vld;
               o_ch  <= m_ch;
               o_smp <= m_smp;
            end
         end
      end else begin : g_thru
         assign o_vld = m_vld;
         assign o_ch  = m_ch;
         assign o_smp = m_smp;
      end
   endgenerate

endmodule

// File: rtl/lim_watch_cmp.sv
module lim_watch_cmp
   import lim_watch_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int CH_W   = 3,
   parameter int SMP_W  = 24
) (
   input  logic              vld,
   input  logic [CH_W-1:0]   ch,
   input  logic [SMP_W-1:0]  smp,
   input  logic [SMP_W-1:0]  thr_hi,
   input  logic [SMP_W-1:0]  thr_lo,
   input  logic [NUM_CH-1:0] ch_mask,
   output logic [NUM_CH-1:0] hit_hi,
   output logic [NUM_CH-1:0] hit_lo
);

   lw_cmp_t res;

   always_comb begin
      res.above = $signed(smp) > $signed(thr_hi);
      res.below = $signed(smp) < $signed(thr_lo);
   end

   // Channel decode; tags that name no channel select nothing
   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
         logic sel_i;
         assign sel_i     = vld && (ch == CH_W'(i)) && ch_mask[i];
         assign hit_hi[i] = sel_i && res.above;
         assign hit_lo[i] = sel_i && res.below;
      end
   endgenerate

endmodule

// File: rtl/lim_watch_flags.sv
module lim_watch_flags #(
   parameter int NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_v,
   input  logic [NUM_CH-1:0] clr_v,
   output logic [NUM_CH-1:0] flag_v
);

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               flag_v[i] <= 1'b0;
            else if (set_v[i])
               flag_v[i] <= 1'b1;
            else if (clr_v[i])
               flag_v[i] <= 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/lim_watch.sv
module lim_watch
   import lim_watch_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int SMP_W  = 24,
   parameter bit REG_IN = 1'b1,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_sel,
   input  logic              main_vld,
   input  logic [CH_W-1:0]   main_ch,
   input  logic [SMP_W-1:0]  main_smp,
   input  logic              wd_vld,
   input  logic [CH_W-1:0]   wd_ch,
   input  logic [SMP_W-1:0]  wd_smp,
   input  logic [SMP_W-1:0]  thr_hi,
   input  logic [SMP_W-1:0]  thr_lo,
   input  logic [NUM_CH-1:0] ch_mask,
   input  logic              irq_en,
   input  logic [NUM_CH-1:0] clr_lo,
   input  logic [NUM_CH-1:0] clr_hi,
   output logic [NUM_CH-1:0] flag_lo,
   output logic [NUM_CH-1:0] flag_hi,
   output logic              irq
);

   generate
      if (NUM_CH < 1 || NUM_CH > LW_MAX_CH) begin : g_bad_ch
         $error("lim_watch: NUM_CH out of range");
      end
      if (SMP_W < 2) begin : g_bad_w
         $error("lim_watch: SMP_W must be at least 2");
      end
   endgenerate

   logic             s_vld;
   logic [CH_W-1:0]  s_ch;
   logic [SMP_W-1:0] s_smp;
   logic [NUM_CH-1:0] hit_hi;
   logic [NUM_CH-1:0] hit_lo;

   lim_watch_src #(
      .CH_W   (CH_W),
      .SMP_W  (SMP_W),
      .REG_IN (REG_IN)
   ) u_src (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (lw_src_e'(src_sel)),
      .a_vld (main_vld),
      .a_ch  (main_ch),
      .a_smp (main_smp),
      .b_vld (wd_vld),
      .b_ch  (wd_ch),
      .b_smp (wd_smp),
      .o_vld (s_vld),
      .o_ch  (s_ch),
      .o_smp (s_smp)
   );

   lim_watch_cmp #(
      .NUM_CH (NUM_CH),
      .CH_W   (CH_W),
      .SMP_W  (SMP_W)
   ) u_cmp (
      .vld     (s_vld),
      .ch      (s_ch),
      .smp     (s_smp),
      .thr_hi  (thr_hi),
      .thr_lo  (thr_lo),
      .ch_mask (ch_mask),
      .hit_hi  (hit_hi),
      .hit_lo  (hit_lo)
   );

   lim_watch_flags #(.NUM_CH(NUM_CH)) u_flags_hi (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_v  (hit_hi),
      .clr_v  (clr_hi),
      .flag_v (flag_hi)
   );

   lim_watch_flags #(.NUM_CH(NUM_CH)) u_flags_lo (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_v  (hit_lo),
      .clr_v  (clr_lo),
      .flag_v (flag_lo)
   );

   assign irq = irq_en && ((|flag_hi) || (|flag_lo));

endmodule

// File: rtl/lim_watch_chk.sv
module lim_watch_chk #(
   parameter int NUM_CH = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] ch_mask,
   input logic              irq_en,
   input logic [NUM_CH-1:0] clr_lo,
   input logic [NUM_CH-1:0] clr_hi,
   input logic [NUM_CH-1:0] flag_lo,
   input logic [NUM_CH-1:0] flag_hi,
   input logic              irq
);

   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (flag_lo == '0 && flag_hi == '0 && !irq));

   a_r6_mask_hi: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flag_hi & ~$past(flag_hi) & ~$past(ch_mask)) == '0));

   a_r6_mask_lo: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flag_lo & ~$past(flag_lo) & ~$past(ch_mask)) == '0));

   a_r7_sticky_hi: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((~flag_hi & $past(flag_hi) & ~$past(clr_hi)) == '0));

   a_r7_sticky_lo: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((~flag_lo & $past(flag_lo) & ~$past(clr_lo)) == '0));

   a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);

   a_r9_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && ((|flag_lo) || (|flag_hi))) |-> irq);

   a_r10_one_rise: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(flag_hi & ~$past(flag_hi)) <= 1 &&
                $countones(flag_lo & ~$past(flag_lo)) <= 1));

endmodule

bind lim_watch lim_watch_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ch_mask (ch_mask),
   .irq_en  (irq_en),
   .clr_lo  (clr_lo),
   .clr_hi  (clr_hi),
   .flag_lo (flag_lo),
   .flag_hi (flag_hi),
   .irq     (irq)
);

// File: tb/lim_watch_bench.sv
module lim_watch_bench;

   localparam int NCH = 8;
   localparam int SW  = 24;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           src_sel = 1'b0;
   logic           main_vld = 1'b0;
   logic [2:0]     main_ch = '0;
   logic [SW-1:0]  main_smp = '0;
   logic           wd_vld = 1'b0;
   logic [2:0]     wd_ch = '0;
   logic [SW-1:0]  wd_smp = '0;
   logic [SW-1:0]  thr_hi = '0;
   logic [SW-1:0]  thr_lo = '0;
   logic [NCH-1:0] ch_mask = '0;
   logic           irq_en = 1'b0;
   logic [NCH-1:0] clr_lo = '0;
   logic [NCH-1:0] clr_hi = '0;
   logic [NCH-1:0] flag_lo;
   logic [NCH-1:0] flag_hi;
   logic           irq;

   lim_watch u_lim_watch (
      .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
      .main_vld(main_vld), .main_ch(main_ch), .main_smp(main_smp),
      .wd_vld(wd_vld), .wd_ch(wd_ch), .wd_smp(wd_smp),
      .thr_hi(thr_hi), .thr_lo(thr_lo), .ch_mask(ch_mask),
      .irq_en(irq_en), .clr_lo(clr_lo), .clr_hi(clr_hi),
      .flag_lo(flag_lo), .flag_hi(flag_hi), .irq(irq)
   );

   always #2.5 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   int cyc    = 0;

   logic [NCH-1:0] exp_lo = '0;
   logic [NCH-1:0] exp_hi = '0;
   int hi_i, lo_i;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 20000 && !done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog expired: actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic set_thr(input int hi, input int lo);
      @(negedge clk);
      hi_i = hi; lo_i = lo;
      thr_hi = SW'(hi);
      thr_lo = SW'(lo);
   endtask

   // Send one sample on the chosen stream with a tripping decoy on the other
   task automatic send(input int src, input int ch, input int val, input logic [NCH-1:0] extra_clr_hi);
      @(negedge clk);
      src_sel = src[0];
      if (src == 0) begin
         main_vld = 1'b1; main_ch = 3'(ch); main_smp = SW'(val);
         wd_vld = 1'b1; wd_ch = 3'((ch + 1) % NCH); wd_smp = SW'(8000000);
      end else begin
         wd_vld = 1'b1; wd_ch = 3'(ch); wd_smp = SW'(val);
         main_vld = 1'b1; main_ch = 3'((ch + 1) % NCH); main_smp = SW'(-8000000);
      end
      if (ch_mask[ch]) begin
         if (val > hi_i) exp_hi[ch] = 1'b1;
         if (val < lo_i) exp_lo[ch] = 1'b1;
      end
      @(negedge clk);
      main_vld = 1'b0; wd_vld = 1'b0;
      clr_hi = extra_clr_hi;
      exp_hi = exp_hi & ~(extra_clr_hi & ~((ch_mask[ch] && val > hi_i) ? (NCH'(1) << ch) : '0));
      @(negedge clk);
      clr_hi = '0;
   endtask

   task automatic clear(input logic [NCH-1:0] lo_m, input logic [NCH-1:0] hi_m);
      @(negedge clk);
      clr_lo = lo_m; clr_hi = hi_m;
      @(negedge clk);
      clr_lo = '0; clr_hi = '0;
      exp_lo = exp_lo & ~lo_m;
      exp_hi = exp_hi & ~hi_m;
   endtask

   int vals[6];

   initial begin
      #1;
      chk("R1 flag_lo in reset", 32'(flag_lo), 32'h0);
      chk("R1 flag_hi in reset", 32'(flag_hi), 32'h0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 flags after reset", 32'({flag_hi, flag_lo}), 32'h0);
      chk("R1 irq after reset", 32'(irq), 32'h0);

      // Sweep: both streams, two limit pairs, every channel, boundary values
      ch_mask = 8'b1011_0111;
      for (int ts = 0; ts < 2; ts++) begin
         if (ts == 0) begin
            set_thr(100, -100);
            vals = '{101, 100, -100, -101, 0, -200};
         end else begin
            set_thr(-5, -50);
            vals = '{-4, -5, -50, -51, -27, 10};
         end
         for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < NCH; c++) begin
               for (int v = 0; v < 6; v++) begin
                  send(s, c, vals[v], '0);
                  chk("R2 R3 R4 R5 R6 R10 flag_hi", 32'(flag_hi), 32'(exp_hi));
                  chk("R2 R3 R4 R5 R6 R10 flag_lo", 32'(flag_lo), 32'(exp_lo));
               end
               clear('1, '1);
               chk("R7 clear all", 32'({flag_hi, flag_lo}), 32'h0);
            end
         end
      end

      // Selective clear keeps the other flags
      ch_mask = '1;
      set_thr(100, -100);
      send(0, 2, 500, '0);
      send(0, 6, 500, '0);
      send(1, 4, -500, '0);
      clear('0, 8'h04);
      chk("R7 selective clear flag_hi", 32'(flag_hi), 32'h40);
      chk("R7 selective clear flag_lo", 32'(flag_lo), 32'h10);

      // Interrupt gating
      chk("R9 irq disabled with flags", 32'(irq), 32'h0);
      @(negedge clk); irq_en = 1'b1;
      #1 chk("R9 irq enabled with flags", 32'(irq), 32'h1);
      clear('0, 8'h40);
      chk("R9 irq with low flag only", 32'(irq), 32'h1);
      clear(8'h10, '0);
      chk("R9 irq with no flags", 32'(irq), 32'h0);

      // Set and clear in the same cycle: set wins, other cleared
      send(0, 3, 200, '0);
      send(0, 5, 200, '0);
      send(0, 3, 300, 8'h28);
      chk("R8 set beats clear", 32'(flag_hi), 32'h08);
      clear('1, '1);
      chk("R7 final clear", 32'({flag_hi, flag_lo}), 32'h0);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule